// File: doc/BRIEF.md
# Deep Sleep Entry and Exit Sequencer

This block takes a platform into and back out of its deepest sleep state, the one in which the suspend power well is switched off. When the rest of the sleep logic requests deep sleep, the sequencer first drives an active-low warning output. It then waits for the platform to return an acknowledge. Only after that does it drive the active-low suspend-well shutoff output. While the well is off, the sequencer watches a power button, an RTC alarm, a dedicated GPIO wake line and an AC-presence line. Each of these sources is qualified by its own configuration input. A qualified wake releases the shutoff and clears the warning, and the block reports the wake to the host sleep logic with a one-cycle pulse.

The sequencer also supports a policy under which deep sleep is allowed only on battery. With that policy active, AC power appearing powers the suspend well up provisionally while the system stays in soft-off. If AC goes away again before any real wake source fires, the well is shut off once more. All pin inputs from the platform pass through two-flop synchronizers. The deep-sleep request and the configuration bits are taken as synchronous inputs.

Top module: `deep_sleep_seq`

## Requirements
- R1: While reset is held and on the first cycles after it, suspWarnN and suspOffN are 1 and wakeOut is 0.
- R2: In the active state, with sleepReq at 1 and no qualified wake pending, suspWarnN goes to 0 at the next clock edge while suspOffN stays 1. suspOffN is 0 only while suspWarnN is 0.
- R3: suspOffN goes to 0 on the third clock edge after ackIn rises while the warning is out. Without ackIn it stays 1 indefinitely. ackIn in the active state has no effect.
- R4: The power button (pwrBtn = 1) always wakes the deep state. On the third edge after it rises, suspOffN and suspWarnN both return to 1.
- R5: gpioWake wakes only when gpioWakeEn = 1. rtcAlarm wakes only when rtcWakeDis = 0. When a source is not qualified, the deep state holds.
- R6: A real wake raises wakeOut for exactly one cycle, together with the release of both outputs. The block then stays awake, without re-entering the warning, until sleepReq returns to 0.
- R7: A qualified wake seen during the warning aborts the entry. suspWarnN returns to 1 on the third edge, suspOffN never falls, and wakeOut stays 0.
- R8: With acWakeEn = 1, a rising acPresent in the deep state is a full wake, exactly like R4.
- R9: With batteryOnly = 1 and acWakeEn = 0, a rising acPresent in the deep state sets suspOffN to 1 on the third edge while suspWarnN stays 0 and wakeOut stays 0. With batteryOnly = 0 and acWakeEn = 0, acPresent has no effect.
- R10: In the provisional AC state, acPresent falling puts suspOffN back to 0 on the third edge. A qualified wake from another source instead gives a full wake as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sleepReq | input | 1 | Synchronous request to enter deep sleep |
| batteryOnly | input | 1 | Policy: deep sleep allowed only on battery |
| acWakeEn | input | 1 | AC presence acts as a wake source |
| gpioWakeEn | input | 1 | GPIO line acts as a wake source |
| rtcWakeDis | input | 1 | Disables the RTC alarm as a wake source |
| ackIn | input | 1 | Platform acknowledge of the warning (asynchronous) |
| rtcAlarm | input | 1 | RTC alarm (asynchronous) |
| pwrBtn | input | 1 | Debounced power button press, active high (asynchronous) |
| gpioWake | input | 1 | Dedicated GPIO wake line (asynchronous) |
| acPresent | input | 1 | AC adapter present (asynchronous) |
| suspWarnN | output | 1 | Active-low warning that suspend-well shutoff is imminent |
| suspOffN | output | 1 | Active-low suspend-well shutoff |
| wakeOut | output | 1 | One-cycle pulse reporting a real deep-state wake |

## Verification
A change of sleepReq shows on the outputs after one clock edge. A change on any asynchronous pin takes two synchronizer edges plus the state edge, so it shows on the third edge. The wake pulse is high in the cycle after that third edge and low in the next one. The bench drives every stimulus just after a falling edge. For each stimulus it stamps each expected output triple with the exact rising-edge count at which it becomes due, and the monitor compares only when the edge counter reaches that stamp. Runs of held expectations after each step show that ignored inputs and gated sources change nothing in the window where they could have acted.

// File: rtl/deep_sleep_pkg.sv
package deep_sleep_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_WARN,
    ST_DEEP,
    ST_AC_PROV,
    ST_WAKE
  } seqState_e;

  // strobes from control to the output registers in the datapath
  typedef struct packed {
    logic setWarn;
    logic clrWarn;
    logic setOff;
    logic clrOff;
    logic pulseWake;
  } ctrlStrobe_t;

  // qualified, synchronized conditions from datapath to control
  typedef struct packed {
    logic wakeAny;
    logic pwrSync;
    logic ackSync;
    logic acSync;
    logic acRise;
  } dpStatus_t;

endpackage

// File: rtl/dsleep_sync.sv
module dsleep_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dsleep_datapath.sv
module dsleep_datapath
  import deep_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackIn,
  input  logic        rtcAlarm,
  input  logic        pwrBtn,
  input  logic        gpioWake,
  input  logic        acPresent,
  input  logic        rtcWakeDis,
  input  logic        gpioWakeEn,
  input  logic        acWakeEn,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        suspWarnN,
  output logic        suspOffN,
  output logic        wakeOut
);

  localparam int IDX_ACK   = 0;
  localparam int IDX_RTC   = 1;
  localparam int IDX_PWR   = 2;
  localparam int IDX_GPIO  = 3;
  localparam int IDX_AC    = 4;
  localparam int NUM_ASYNC = IDX_AC + 1;

  logic [NUM_ASYNC-1:0] pinRaw, pinSync;
  logic                 acPrev;

  assign pinRaw[IDX_ACK]  = ackIn;
  assign pinRaw[IDX_RTC]  = rtcAlarm;
  assign pinRaw[IDX_PWR]  = pwrBtn;
  assign pinRaw[IDX_GPIO] = gpioWake;
  assign pinRaw[IDX_AC]   = acPresent;

  dsleep_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinRaw),
    .syncOut (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acPrev <= 1'b0;
    else       acPrev <= pinSync[IDX_AC];
  end

  always_comb begin
    status.pwrSync = pinSync[IDX_PWR];
    status.ackSync = pinSync[IDX_ACK];
    status.acSync  = pinSync[IDX_AC];
    status.acRise  = pinSync[IDX_AC] & ~acPrev;
    status.wakeAny = pinSync[IDX_PWR]
                   | (pinSync[IDX_GPIO] & gpioWakeEn)
                   | (pinSync[IDX_RTC]  & ~rtcWakeDis)
                   | (pinSync[IDX_AC]   & acWakeEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspWarnN <= 1'b1;
      suspOffN  <= 1'b1;
      wakeOut   <= 1'b0;
    end else begin
      if (strobe.setWarn)      suspWarnN <= 1'b0;
      else if (strobe.clrWarn) suspWarnN <= 1'b1;
      if (strobe.setOff)       suspOffN  <= 1'b0;
      else if (strobe.clrOff)  suspOffN  <= 1'b1;
      wakeOut <= strobe.pulseWake;
    end
  end

  // R2: the well is only ever off while the warning is out
  p_off_implies_warn_r2: assert property (@(posedge clk) disable iff (!rstN)
    !suspOffN |-> !suspWarnN);

  // R6: the wake report is a single-cycle pulse
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |=> !wakeOut);

  // R6: the pulse coincides with both outputs released
  p_wake_released_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (suspOffN && suspWarnN));

endmodule

// File: rtl/dsleep_ctrl.sv
module dsleep_ctrl
  import deep_sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sleepReq,
  input  logic        batteryOnly,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);

  seqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        if (sleepReq && !status.wakeAny) begin
          nextState      = ST_WARN;
          strobe.setWarn = 1'b1;
        end
      end
      ST_WARN: begin
        if (status.wakeAny) begin
          nextState      = ST_ACTIVE;
          strobe.clrWarn = 1'b1;
        end else if (status.ackSync) begin
          nextState     = ST_DEEP;
          strobe.setOff = 1'b1;
        end
      end
      ST_DEEP: begin
        if (status.wakeAny) begin
          nextState        = ST_WAKE;
          strobe.clrOff    = 1'b1;
          strobe.clrWarn   = 1'b1;
          strobe.pulseWake = 1'b1;
        end else if (batteryOnly && status.acRise) begin
          nextState     = ST_AC_PROV;
          strobe.clrOff = 1'b1;
        end
      end
      ST_AC_PROV: begin
        if (status.wakeAny) begin
          nextState        = ST_WAKE;
          strobe.clrOff    = 1'b1;
          strobe.clrWarn   = 1'b1;
          strobe.pulseWake = 1'b1;
        end else if (!status.acSync) begin
          nextState     = ST_DEEP;
          strobe.setOff = 1'b1;
        end
      end
      ST_WAKE: begin
        if (!sleepReq) nextState = ST_ACTIVE;
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  // R3: no shutoff without a synchronized acknowledge
  p_no_ack_no_deep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WARN && !status.ackSync) |=> state != ST_DEEP);

  // R4: the power button always ends the deep state
  p_pwr_wakes_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_DEEP || state == ST_AC_PROV) && status.pwrSync) |=> state == ST_WAKE);

  // R7: a wake during the warning aborts back to active
  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WARN && status.wakeAny) |=> state == ST_ACTIVE);

  // R9: battery-only policy turns an AC edge into a provisional wake
  p_ac_prov_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEEP && !status.wakeAny && batteryOnly && status.acRise)
      |=> state == ST_AC_PROV);

  // R10: AC loss in the provisional state goes back to deep
  p_ac_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_AC_PROV && !status.wakeAny && !status.acSync) |=> state == ST_DEEP);

endmodule

// File: rtl/deep_sleep_seq.sv
module deep_sleep_seq
  import deep_sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic batteryOnly,
  input  logic acWakeEn,
  input  logic gpioWakeEn,
  input  logic rtcWakeDis,
  input  logic ackIn,
  input  logic rtcAlarm,
  input  logic pwrBtn,
  input  logic gpioWake,
  input  logic acPresent,
  output logic suspWarnN,
  output logic suspOffN,
  output logic wakeOut
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  dsleep_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepReq    (sleepReq),
    .batteryOnly (batteryOnly),
    .status      (status),
    .strobe      (strobe)
  );

  dsleep_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ackIn      (ackIn),
    .rtcAlarm   (rtcAlarm),
    .pwrBtn     (pwrBtn),
    .gpioWake   (gpioWake),
    .acPresent  (acPresent),
    .rtcWakeDis (rtcWakeDis),
    .gpioWakeEn (gpioWakeEn),
    .acWakeEn   (acWakeEn),
    .strobe     (strobe),
    .status     (status),
    .suspWarnN  (suspWarnN),
    .suspOffN   (suspOffN),
    .wakeOut    (wakeOut)
  );

endmodule

// File: tb/deep_sleep_seq_bench.sv
`timescale 1ns/1ps
module deep_sleep_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 0, batteryOnly = 0, acWakeEn = 0, gpioWakeEn = 0, rtcWakeDis = 1;
  logic ackIn = 0, rtcAlarm = 0, pwrBtn = 0, gpioWake = 0, acPresent = 0;
  logic suspWarnN, suspOffN, wakeOut;

  always #2.5 clk = ~clk;

  deep_sleep_seq u_deep_sleep_seq (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .batteryOnly(batteryOnly),
    .acWakeEn(acWakeEn), .gpioWakeEn(gpioWakeEn), .rtcWakeDis(rtcWakeDis),
    .ackIn(ackIn), .rtcAlarm(rtcAlarm), .pwrBtn(pwrBtn), .gpioWake(gpioWake),
    .acPresent(acPresent), .suspWarnN(suspWarnN), .suspOffN(suspOffN),
    .wakeOut(wakeOut)
  );

  typedef struct {
    int         due;
    logic [2:0] exp;   // {suspWarnN, suspOffN, wakeOut}
    string      tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each expected item in the cycle it is due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      vectors++;
      if ({suspWarnN, suspOffN, wakeOut} !== it.exp) begin
        misses++;
        $display("FAIL %s at edge %0d: warnN/offN/wake = %b%b%b expected %b",
                 it.tag, cyc, suspWarnN, suspOffN, wakeOut, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectAt(input int d, input logic w, input logic o, input logic p,
                          input string tag);
    item_t it;
    it.due = cyc + d;
    it.exp = {w, o, p};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic hold(input int n, input logic w, input logic o, input logic p,
                      input string tag);
    for (int i = 1; i <= n; i++) expectAt(i, w, o, p, tag);
    tick(n);
  endtask

  task automatic enterDeep();
    sleepReq = 1;
    expectAt(1, 0, 1, 0, "R2 warning");
    tick(1);
    ackIn = 1;
    expectAt(2, 0, 1, 0, "R3 ack in synchronizer");
    expectAt(3, 0, 0, 0, "R3 shutoff after ack");
    tick(3);
    ackIn = 0;
    hold(3, 0, 0, 0, "R3 deep holds");
  endtask

  task automatic leaveWake();
    sleepReq = 0;
    tick(4);
  endtask

  initial begin
    tick(3);
    expectAt(1, 1, 1, 0, "R1 reset state");
    tick(1);
    rstN = 1;
    hold(2, 1, 1, 0, "R1 after reset");

    // R3: ack without a request is ignored
    ackIn = 1;
    hold(5, 1, 1, 0, "R3 ack in active");
    ackIn = 0;
    tick(4);

    // R2 then R3: warning out, no ack means no shutoff
    sleepReq = 1;
    expectAt(1, 0, 1, 0, "R2 warning");
    tick(1);
    hold(6, 0, 1, 0, "R3 no ack no shutoff");
    ackIn = 1;
    expectAt(2, 0, 1, 0, "R3 ack in synchronizer");
    expectAt(3, 0, 0, 0, "R3 shutoff after ack");
    tick(3);
    ackIn = 0;
    hold(3, 0, 0, 0, "R3 deep holds");

    // R5: gated sources do nothing
    gpioWake = 1; rtcAlarm = 1;
    hold(6, 0, 0, 0, "R5 gated sources");
    gpioWake = 0; rtcAlarm = 0;
    tick(4);

    // R4 / R6: power button
    pwrBtn = 1;
    expectAt(2, 0, 0, 0, "R4 button in synchronizer");
    expectAt(3, 1, 1, 1, "R4 button wake");
    expectAt(4, 1, 1, 0, "R6 pulse ends");
    tick(4);
    pwrBtn = 0;
    hold(5, 1, 1, 0, "R6 stays awake while requested");
    leaveWake();

    // R5: enabled GPIO wakes
    gpioWakeEn = 1;
    enterDeep();
    gpioWake = 1;
    expectAt(3, 1, 1, 1, "R5 gpio wake");
    expectAt(4, 1, 1, 0, "R6 pulse ends");
    tick(4);
    gpioWake = 0;
    leaveWake();

    // R5: enabled RTC wakes
    rtcWakeDis = 0;
    enterDeep();
    rtcAlarm = 1;
    expectAt(3, 1, 1, 1, "R5 rtc wake");
    expectAt(4, 1, 1, 0, "R6 pulse ends");
    tick(4);
    rtcAlarm = 0;
    leaveWake();

    // R7: wake during warning aborts
    sleepReq = 1;
    expectAt(1, 0, 1, 0, "R2 warning");
    tick(1);
    pwrBtn = 1;
    expectAt(2, 0, 1, 0, "R7 before abort");
    expectAt(3, 1, 1, 0, "R7 abort");
    tick(3);
    sleepReq = 0;
    hold(5, 1, 1, 0, "R7 no pulse no shutoff");
    pwrBtn = 0;
    tick(4);

    // R9 / R10: battery-only provisional AC wake
    batteryOnly = 1;
    enterDeep();
    acPresent = 1;
    expectAt(2, 0, 0, 0, "R9 ac in synchronizer");
    expectAt(3, 0, 1, 0, "R9 provisional");
    tick(3);
    hold(4, 0, 1, 0, "R9 stays soft-off");
    acPresent = 0;
    expectAt(3, 0, 0, 0, "R10 back to deep");
    tick(3);
    hold(3, 0, 0, 0, "R10 deep holds");
    acPresent = 1;
    expectAt(3, 0, 1, 0, "R9 provisional again");
    tick(4);
    gpioWake = 1;
    expectAt(3, 1, 1, 1, "R10 real wake from provisional");
    expectAt(4, 1, 1, 0, "R6 pulse ends");
    tick(4);
    gpioWake = 0; acPresent = 0;
    leaveWake();

    // R9: policy off, AC ignored
    batteryOnly = 0;
    enterDeep();
    acPresent = 1;
    hold(6, 0, 0, 0, "R9 ac ignored");
    acPresent = 0;
    tick(4);

    // R8: AC enabled as wake source
    acWakeEn = 1;
    acPresent = 1;
    expectAt(3, 1, 1, 1, "R8 ac wake");
    expectAt(4, 1, 1, 0, "R6 pulse ends");
    tick(4);
    acPresent = 0;
    leaveWake();

    wait (q.size() == 0);
    tick(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run hung, %0d items pending expected 0", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule